// File: doc/BRIEF.md
# Multicycle 16-bit Register Processor

This block is a small stored-program processor. It runs 16-bit instructions, and each instruction passes through a sequence of phases: fetch, decode, address evaluation, operand fetch, execute and result write-back. An instruction uses only the phases it needs, so it takes 5, 6, 8 or 9 clock cycles. The processor holds a program counter, an instruction register, a memory address staging register, a memory data staging register and eight general registers of 16 bits each. A finite-state controller steps through the phases. A one-hot opcode decoder selects the control path.

The memory has a synchronous read and sits inside the block. Every access goes through the two staging registers, so the read data reaches the memory data register one cycle after the read is issued. A load port fills the memory, normally while reset is held. A debug select reads any general register without side effects. A one-cycle retire pulse marks the last cycle of each instruction.

Top module: `mc_core`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `pc_o` is 0x0000, all eight registers read 0x0000 and `retire_o` is low. Execution then starts with a fetch at address 0.
- R2: Fetch reads the word at memory index `pc[ADDR_W-1:0]` into the instruction register. The PC then becomes PC+1, modulo 2^16, for every instruction except a jump.
- R3: The opcode is bits [15:12]. The encodings are ADD=0001, AND=0101, LDR=0110, NOT=1001 and JMP=1100. Any other opcode changes no register, advances the PC by one and retires in 5 cycles.
- R4: ADD with bit 5 = 0 writes R[dst] = R[src1] + R[src2] modulo 2^16. Here dst is bits [11:9], src1 is bits [8:6] and src2 is bits [2:0]. Bits [4:3] are ignored.
- R5: ADD or AND with bit 5 = 1 uses the value of bits [4:0], sign-extended to 16 bits, as the second operand.
- R6: AND with bit 5 = 0 writes R[dst] = R[src1] & R[src2].
- R7: NOT writes R[dst] = ~R[src1]. Bits [5:0] are ignored.
- R8: LDR forms R[base] + sign-extend(bits [5:0]), with base in bits [8:6]. It reads the memory at the low ADDR_W bits of that sum and writes the word to R[dst].
- R9: JMP sets the PC to R[bits 8:6] unconditionally and writes no register.
- R10: From one retire pulse to the next takes 8 cycles for ADD, AND and NOT, 9 for LDR, 6 for JMP and 5 for an unknown opcode.
- R11: `retire_o` is high for exactly one cycle per instruction. The cycle after it is always low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Write `load_data` into memory at `load_addr` |
| load_addr | input | ADDR_W | Memory index for program loading |
| load_data | input | 16 | Word to store while loading |
| dbg_sel | input | 3 | General register selected for observation |
| dbg_data | output | 16 | Contents of the selected register |
| pc_o | output | 16 | Current program counter |
| retire_o | output | 1 | High in the last cycle of each instruction |

## Verification
The bench builds the block with the default ADDR_W of 8, which gives 256 words of memory. The 16-bit PC and the LDR addresses then wrap into a space the bench fills completely. Negative LDR offsets from a base of zero land at the top of memory, which tests sign extension. Random jump targets and fall-through into the data area always run defined words, so a long random program can be followed instruction by instruction against a bench model. The model checks the PC, all eight registers and the cycle count of each instruction.

// File: rtl/mc_pkg.sv
package mc_pkg;

    // Architectural sizes (fixed by the instruction format)
    localparam int XLEN   = 16;
    localparam int NREG   = 8;
    localparam int RIDX_W = $clog2(NREG);
    localparam int OPC_W  = 4;
    localparam int NOPC   = 1 << OPC_W;

    // Opcode encodings
    localparam logic [OPC_W-1:0] OPC_ADD = 4'b0001;
    localparam logic [OPC_W-1:0] OPC_AND = 4'b0101;
    localparam logic [OPC_W-1:0] OPC_LDR = 4'b0110;
    localparam logic [OPC_W-1:0] OPC_NOT = 4'b1001;
    localparam logic [OPC_W-1:0] OPC_JMP = 4'b1100;

    // One bit per implemented opcode in the one-hot decode space
    localparam logic [NOPC-1:0] KNOWN_MASK =
        (NOPC'(1) << OPC_ADD) | (NOPC'(1) << OPC_AND) | (NOPC'(1) << OPC_LDR) |
        (NOPC'(1) << OPC_NOT) | (NOPC'(1) << OPC_JMP);

    typedef logic [XLEN-1:0]   word_t;
    typedef logic [RIDX_W-1:0] ridx_t;

    // Controller phases
    typedef enum logic [3:0] {
        PH_FETCH_ADDR,
        PH_FETCH_READ,
        PH_FETCH_DATA,
        PH_FETCH_IR,
        PH_DECODE,
        PH_EVAL_ADDR,
        PH_OPND_READ,
        PH_OPND_DATA,
        PH_OPND_REGS,
        PH_EXECUTE,
        PH_STORE
    } phase_t;

    typedef enum logic [1:0] {
        ALU_ADD,
        ALU_AND,
        ALU_NOT
    } alu_op_t;

    // Instruction fields (several overlap)
    typedef struct packed {
        logic [OPC_W-1:0] opc;
        ridx_t            dst;
        ridx_t            src1;
        logic             imm_sel;
        ridx_t            src2;
        logic [4:0]       imm5;
        logic [5:0]       off6;
    } fields_t;

    // Datapath enables produced by the controller
    typedef struct packed {
        logic ld_mar_pc;
        logic ld_mar_ea;
        logic mem_rd;
        logic ld_mdr;
        logic ld_ir;
        logic pc_inc;
        logic ld_opnd;
        logic ld_temp;
        logic ld_pc_reg;
        logic rf_we;
        logic wb_mdr;
    } ctl_t;

    function automatic fields_t split_instr(word_t w);
        fields_t f;
        f.opc     = w[15:12];
        f.dst     = w[11:9];
        f.src1    = w[8:6];
        f.imm_sel = w[5];
        f.src2    = w[2:0];
        f.imm5    = w[4:0];
        f.off6    = w[5:0];
        return f;
    endfunction

    function automatic word_t sext5(logic [4:0] v);
        return {{(XLEN-5){v[4]}}, v};
    endfunction

    function automatic word_t sext6(logic [5:0] v);
        return {{(XLEN-6){v[5]}}, v};
    endfunction

    function automatic alu_op_t alu_sel(logic [OPC_W-1:0] opc);
        case (opc)
            OPC_AND: return ALU_AND;
            OPC_NOT: return ALU_NOT;
            default: return ALU_ADD;
        endcase
    endfunction

endpackage

// File: rtl/mc_mem.sv
module mc_mem #(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          ld_en,
    input  logic [AW-1:0] ld_addr,
    input  logic [DW-1:0] ld_data,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_q
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    // Synchronous read: data is valid the cycle after rd_en
    always_ff @(posedge clk) begin
        if (ld_en) cells[ld_addr] <= ld_data;
        if (rd_en) rd_q <= cells[rd_addr];
    end

endmodule

// File: rtl/mc_regfile.sv
module mc_regfile
    import mc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  we,
    input  ridx_t waddr,
    input  word_t wdata,
    input  ridx_t ra,
    output word_t rdata_a,
    input  ridx_t rb,
    output word_t rdata_b,
    input  ridx_t dsel,
    output word_t ddata
);
    word_t regs [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (we) begin
            regs[waddr] <= wdata;
        end
    end

    assign rdata_a = regs[ra];
    assign rdata_b = regs[rb];
    assign ddata   = regs[dsel];

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        we |=> regs[$past(waddr)] == $past(wdata)); // R4

endmodule

// File: rtl/mc_alu.sv
module mc_alu
    import mc_pkg::*;
(
    input  alu_op_t op,
    input  word_t   a,
    input  word_t   b,
    output word_t   y
);
    always_comb begin
        case (op)
            ALU_AND: y = a & b;
            ALU_NOT: y = ~a;
            default: y = a + b;
        endcase
    end

endmodule

// File: rtl/mc_ctrl.sv
module mc_ctrl
    import mc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [OPC_W-1:0] opc,
    output phase_t           phase,
    output ctl_t             ctl,
    output logic [NOPC-1:0]  dec_hot,
    output logic             retire
);
    phase_t nxt;
    logic   is_alu, is_ldr, is_jmp, is_unknown;

    // 4-to-16 one-hot opcode decoder
    for (genvar g = 0; g < NOPC; g++) begin : g_dec
        assign dec_hot[g] = (opc == OPC_W'(g));
    end

    assign is_alu     = dec_hot[OPC_ADD] | dec_hot[OPC_AND] | dec_hot[OPC_NOT];
    assign is_ldr     = dec_hot[OPC_LDR];
    assign is_jmp     = dec_hot[OPC_JMP];
    assign is_unknown = ~|(dec_hot & KNOWN_MASK);

    always_comb begin
        nxt = phase;
        case (phase)
            PH_FETCH_ADDR: nxt = PH_FETCH_READ;
            PH_FETCH_READ: nxt = PH_FETCH_DATA;
            PH_FETCH_DATA: nxt = PH_FETCH_IR;
            PH_FETCH_IR:   nxt = PH_DECODE;
            PH_DECODE: begin
                if (is_alu)      nxt = PH_OPND_REGS;
                else if (is_ldr) nxt = PH_EVAL_ADDR;
                else if (is_jmp) nxt = PH_EXECUTE;
                else             nxt = PH_FETCH_ADDR;
            end
            PH_EVAL_ADDR:  nxt = PH_OPND_READ;
            PH_OPND_READ:  nxt = PH_OPND_DATA;
            PH_OPND_DATA:  nxt = PH_STORE;
            PH_OPND_REGS:  nxt = PH_EXECUTE;
            PH_EXECUTE:    nxt = is_jmp ? PH_FETCH_ADDR : PH_STORE;
            PH_STORE:      nxt = PH_FETCH_ADDR;
            default:       nxt = PH_FETCH_ADDR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) phase <= PH_FETCH_ADDR;
        else     phase <= nxt;
    end

    always_comb begin
        ctl = '0;
        case (phase)
            PH_FETCH_ADDR: ctl.ld_mar_pc = 1'b1;
            PH_FETCH_READ: ctl.mem_rd    = 1'b1;
            PH_FETCH_DATA: ctl.ld_mdr    = 1'b1;
            PH_FETCH_IR: begin
                ctl.ld_ir  = 1'b1;
                ctl.pc_inc = 1'b1;
            end
            PH_EVAL_ADDR:  ctl.ld_mar_ea = 1'b1;
            PH_OPND_READ:  ctl.mem_rd    = 1'b1;
            PH_OPND_DATA:  ctl.ld_mdr    = 1'b1;
            PH_OPND_REGS:  ctl.ld_opnd   = 1'b1;
            PH_EXECUTE: begin
                ctl.ld_temp   = ~is_jmp;
                ctl.ld_pc_reg = is_jmp;
            end
            PH_STORE: begin
                ctl.rf_we  = 1'b1;
                ctl.wb_mdr = is_ldr;
            end
            default: ;
        endcase
    end

    // Last cycle of every instruction: the phase that hands back to fetch
    assign retire = (phase == PH_STORE) ||
                    (phase == PH_EXECUTE && is_jmp) ||
                    (phase == PH_DECODE && is_unknown);

    AST_RETIRE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        retire |=> !retire); // R11

    AST_UNKNOWN_REFETCH: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_DECODE && is_unknown) |=> phase == PH_FETCH_ADDR); // R3

endmodule

// File: rtl/mc_core.sv
module mc_core
    import mc_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_en,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [XLEN-1:0]   load_data,
    input  logic [RIDX_W-1:0] dbg_sel,
    output logic [XLEN-1:0]   dbg_data,
    output logic [XLEN-1:0]   pc_o,
    output logic              retire_o
);
    // Architectural and staging registers
    word_t             pc_q, ir_q, mdr_q, opa_q, opb_q, temp_q;
    logic [ADDR_W-1:0] mar_q;

    fields_t          f;
    phase_t           phase;
    ctl_t             ctl;
    logic [NOPC-1:0]  dec_hot;
    logic             retire;
    word_t            mem_q, rd_a, rd_b, alu_y, wb_data;

    assign f = split_instr(ir_q);

    mc_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .opc     (f.opc),
        .phase   (phase),
        .ctl     (ctl),
        .dec_hot (dec_hot),
        .retire  (retire)
    );

    mc_mem #(.AW(ADDR_W), .DW(XLEN)) u_mem (
        .clk     (clk),
        .ld_en   (load_en),
        .ld_addr (load_addr),
        .ld_data (load_data),
        .rd_en   (ctl.mem_rd),
        .rd_addr (mar_q),
        .rd_q    (mem_q)
    );

    assign wb_data = ctl.wb_mdr ? mdr_q : temp_q;

    mc_regfile u_rf (
        .clk     (clk),
        .rst     (rst),
        .we      (ctl.rf_we),
        .waddr   (f.dst),
        .wdata   (wb_data),
        .ra      (f.src1),
        .rdata_a (rd_a),
        .rb      (f.src2),
        .rdata_b (rd_b),
        .dsel    (dbg_sel),
        .ddata   (dbg_data)
    );

    mc_alu u_alu (
        .op (alu_sel(f.opc)),
        .a  (opa_q),
        .b  (opb_q),
        .y  (alu_y)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q   <= '0;
            ir_q   <= '0;
            mar_q  <= '0;
            mdr_q  <= '0;
            opa_q  <= '0;
            opb_q  <= '0;
            temp_q <= '0;
        end else begin
            if (ctl.ld_mar_pc)      mar_q <= pc_q[ADDR_W-1:0];
            else if (ctl.ld_mar_ea) mar_q <= ADDR_W'(rd_a + sext6(f.off6));
            if (ctl.ld_mdr)         mdr_q <= mem_q;
            if (ctl.ld_ir)          ir_q  <= mdr_q;
            if (ctl.pc_inc)         pc_q  <= pc_q + 16'd1;
            else if (ctl.ld_pc_reg) pc_q  <= rd_a;
            if (ctl.ld_opnd) begin
                opa_q <= rd_a;
                opb_q <= f.imm_sel ? sext5(f.imm5) : rd_b;
            end
            if (ctl.ld_temp)        temp_q <= alu_y;
        end
    end

    assign pc_o     = pc_q;
    assign retire_o = retire;

    AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_FETCH_IR) |=> pc_q == $past(pc_q) + 16'd1); // R2

    AST_IR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_FETCH_IR) |=> $stable(ir_q)); // R2

    AST_JMP_TARGET: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_EXECUTE && f.opc == OPC_JMP) |=> pc_q == $past(rd_a)); // R9

    AST_NOP_PC_HOLD: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_DECODE && ~|(dec_hot & KNOWN_MASK)) |=> $stable(pc_q)); // R3

endmodule

// File: tb/mc_core_test.sv
`timescale 1ns/10ps
module mc_core_test;

    localparam int AW    = 8;
    localparam int DEPTH = 1 << AW;
    localparam int NINST = 400;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          load_en = 1'b0;
    logic [AW-1:0] load_addr = '0;
    logic [15:0]   load_data = '0;
    logic [2:0]    dbg_sel = '0;
    logic [15:0]   dbg_data, pc_o;
    logic          retire_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [15:0] m_mem [DEPTH];
    logic [15:0] m_reg [8];
    logic [15:0] m_pc;

    always #2 clk = ~clk;

    mc_core #(.ADDR_W(AW)) uut (
        .clk       (clk),
        .rst       (rst),
        .load_en   (load_en),
        .load_addr (load_addr),
        .load_data (load_data),
        .dbg_sel   (dbg_sel),
        .dbg_data  (dbg_data),
        .pc_o      (pc_o),
        .retire_o  (retire_o)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [15:0] enc(logic [3:0] opc, logic [2:0] d,
                                        logic [2:0] s, logic [5:0] low);
        return {opc, d, s, low};
    endfunction

    function automatic logic [15:0] sx(logic [15:0] v, int bits);
        logic [15:0] r = v;
        for (int i = bits; i < 16; i++) r[i] = v[bits-1];
        return r;
    endfunction

    function automatic logic [15:0] rand_instr();
        int k = $urandom_range(0, 15);
        logic [2:0] d = 3'($urandom_range(0, 7));
        logic [2:0] s = 3'($urandom_range(0, 7));
        logic [5:0] low = 6'($urandom_range(0, 63));
        logic [3:0] op;
        if (k <= 2 || k >= 13) op = 4'b0001;
        else if (k <= 5)       op = 4'b0101;
        else if (k <= 7)       op = 4'b1001;
        else if (k <= 10)      op = 4'b0110;
        else if (k == 11)      op = 4'b1100;
        else begin
            op = 4'($urandom_range(0, 15));
            while (op == 4'b0001 || op == 4'b0101 || op == 4'b0110 ||
                   op == 4'b1001 || op == 4'b1100)
                op = 4'($urandom_range(0, 15));
        end
        return enc(op, d, s, low);
    endfunction

    // Reference step: updates the model, returns cycle length and tag
    task automatic model_step(output int len, output string tag, output bit is_jmp);
        logic [15:0] w = m_mem[m_pc[AW-1:0]];
        logic [2:0]  d = w[11:9];
        logic [2:0]  s1 = w[8:6];
        logic [15:0] a = m_reg[s1];
        logic [15:0] b = w[5] ? sx({11'b0, w[4:0]}, 5) : m_reg[w[2:0]];
        logic [15:0] ea;
        is_jmp = 1'b0;
        m_pc = m_pc + 16'd1;
        case (w[15:12])
            4'b0001: begin m_reg[d] = a + b; len = 8; tag = w[5] ? "R5" : "R4"; end
            4'b0101: begin m_reg[d] = a & b; len = 8; tag = w[5] ? "R5" : "R6"; end
            4'b1001: begin m_reg[d] = ~a;    len = 8; tag = "R7"; end
            4'b0110: begin
                ea = a + sx({10'b0, w[5:0]}, 6);
                m_reg[d] = m_mem[ea[AW-1:0]];
                len = 9; tag = "R8";
            end
            4'b1100: begin m_pc = a; len = 6; tag = "R9"; is_jmp = 1'b1; end
            default: begin len = 5; tag = "R3"; end
        endcase
    endtask

    task automatic check_regs(input string tag);
        for (int r = 0; r < 8; r++) begin
            dbg_sel = 3'(r);
            #0.1;
            chk(tag, $sformatf("reg %0d", r), {16'b0, dbg_data}, {16'b0, m_reg[r]});
        end
    endtask

    initial begin : watchdog
        repeat (30000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin : main
        int len, n;
        string tag;
        bit jmp;
        void'($urandom(32'd20240611));

        // Build program image
        for (int i = 0; i < DEPTH; i++) m_mem[i] = 16'($urandom_range(0, 65535));
        for (int i = 14; i < 224; i++) m_mem[i] = rand_instr();
        m_mem[224] = 16'hFFFF;
        m_mem[225] = 16'h0001;
        for (int k = 0; k < 7; k++)
            m_mem[k] = enc(4'b0110, 3'(7 - k), 3'd0, 6'(k - 32)); // R8 negative offsets
        m_mem[7]  = enc(4'b0110, 3'd0, 3'd0, 6'(-25));
        m_mem[8]  = enc(4'b0001, 3'd6, 3'd6, 6'b011_111);  // R4 reg mode, bits 4:3 set
        m_mem[9]  = enc(4'b0001, 3'd1, 3'd1, 6'b111111);   // R5 imm -1
        m_mem[10] = enc(4'b1001, 3'd2, 3'd3, 6'b101010);   // R7
        m_mem[11] = enc(4'b0101, 3'd4, 3'd5, 6'b101111);   // R5 imm 15
        m_mem[12] = 16'hF0A5;                              // R3 unknown
        m_mem[13] = 16'h0000;                              // R3 unknown

        // Load memory while in reset
        for (int i = 0; i < DEPTH; i++) begin
            @(negedge clk);
            load_en = 1'b1;
            load_addr = AW'(i);
            load_data = m_mem[i];
        end
        @(negedge clk);
        load_en = 1'b0;
        for (int r = 0; r < 8; r++) m_reg[r] = 16'h0;
        m_pc = 16'h0;

        // R1 reset state
        chk("R1", "pc in reset", {16'b0, pc_o}, 32'h0);
        chk("R1", "retire in reset", {31'b0, retire_o}, 32'h0);
        check_regs("R1");
        @(negedge clk);
        rst = 1'b0;
        chk("R1", "pc after release", {16'b0, pc_o}, 32'h0);

        for (int it = 0; it < NINST; it++) begin
            n = 0;
            do begin
                @(posedge clk);
                @(negedge clk);
                n++;
            end while (retire_o !== 1'b1 && n < 40);
            model_step(len, tag, jmp);
            chk("R10", $sformatf("cycles for %s", tag), n + 1, len);
            @(posedge clk);
            @(negedge clk);
            chk("R11", "retire low after pulse", {31'b0, retire_o}, 32'h0);
            chk(jmp ? "R9" : "R2", "pc", {16'b0, pc_o}, {16'b0, m_pc});
            check_regs(tag);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule